// File: doc/BRIEF.md
# Adder-Tree Thermometer-to-Binary Encoder

This block turns the seven-bit word from the comparator bank of a three-bit flash converter into a three-bit binary code. It does not use a priority or lookup decoder. It counts the ones in the word with four full adders wired as a small tree. Each adder is two 2:1 multiplexers that both select on the carry-in. Because the result is a ones count, a word that contains a bubble still yields its population count, and there is no separate correction stage.

A sample is offered by raising `in_valid_i` with the comparator word on `therm_i`. The word is captured on that rising edge. Its code appears on `code_o`, with `code_vld_o` high, one clock edge later. Between samples the code output keeps its last value.

Top module: `therm_adder_enc`

## Requirements
- R1: While `rst_n` is low, `code_o` is 000 and `code_vld_o` is 0. Both still hold those values in the cycle in which reset is released.
- R2: A proper thermometer word, in which ones fill bit 0 upward with k ones and only zeros above them, produces binary k. All zeros gives 000 and all seven ones gives 111.
- R3: Any seven-bit word, with bubbles included, produces the number of ones it contains. All 128 patterns are covered.
- R4: A word captured at the edge where `in_valid_i` is high appears on `code_o` with `code_vld_o` high at the next rising edge. `code_vld_o` is high for exactly one cycle per captured word.
- R5: When no word was captured at the previous edge, `code_vld_o` is 0 and `code_o` keeps its previous value.
- R6: Words offered on consecutive cycles produce codes on consecutive cycles, in the same order and with none dropped.
- R7: Changes on `therm_i` while `in_valid_i` is low have no effect on `code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid_i | input | 1 | Capture strobe for `therm_i` |
| therm_i | input | 7 | Comparator outputs, bit 0 is the lowest reference tap |
| code_o | output | 3 | Binary ones count of the last captured word |
| code_vld_o | output | 1 | High for one cycle when `code_o` carries a fresh result |

## Verification
In a back-to-back stream, the capture of a new word and the presentation of the previous word's code happen at the same edge. All 128 patterns are pushed on consecutive cycles to provoke this. Each output is judged against a popcount of the word offered two sampling points earlier. A separate idle run toggles `therm_i` with the strobe low, to check that the held code is not disturbed while the capture stage sits empty.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;
  localparam int CODE_W  = 3;
  localparam int THERM_W = (1 << CODE_W) - 1;
  typedef logic [THERM_W-1:0] therm_t;
  typedef logic [CODE_W-1:0]  code_t;
endpackage

// File: rtl/sel_mux2.sv
module sel_mux2 (
  input  logic sel_i,
  input  logic lo_i,
  input  logic hi_i,
  output logic y_o
);
  assign y_o = sel_i ? hi_i : lo_i;
endmodule

// File: rtl/fa_mux_cell.sv
// Full adder as two multiplexers steered by carry-in.
module fa_mux_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic ab_xor;
  logic ab_and;
  logic ab_or;

  assign ab_xor = a_i ^ b_i;
  assign ab_and = a_i & b_i;
  assign ab_or  = a_i | b_i;

  sel_mux2 u_sum_mux (
    .sel_i (c_i),
    .lo_i  (ab_xor),
    .hi_i  (~ab_xor),
    .y_o   (s_o)
  );

  sel_mux2 u_carry_mux (
    .sel_i (c_i),
    .lo_i  (ab_and),
    .hi_i  (ab_or),
    .y_o   (co_o)
  );
endmodule

// File: rtl/ones_adder_tree.sv
// Fixed 7:3 ones counter built from four full-adder cells.
module ones_adder_tree import therm_enc_pkg::*; (
  input  therm_t word_i,
  output code_t  count_o
);
  logic upper_s, upper_c;
  logic lower_s, lower_c;
  logic low_s,   low_c;
  logic top_s,   top_c;

  // upper group: bits 6..4
  fa_mux_cell u_fa_upper (
    .a_i (word_i[6]), .b_i (word_i[5]), .c_i (word_i[4]),
    .s_o (upper_s),   .co_o (upper_c)
  );

  // lower group: bits 3..1
  fa_mux_cell u_fa_lower (
    .a_i (word_i[3]), .b_i (word_i[2]), .c_i (word_i[1]),
    .s_o (lower_s),   .co_o (lower_c)
  );

  // weight-1 column: both group sums plus bit 0
  fa_mux_cell u_fa_ones (
    .a_i (upper_s), .b_i (lower_s), .c_i (word_i[0]),
    .s_o (low_s),   .co_o (low_c)
  );

  // weight-2 column: the three carries
  fa_mux_cell u_fa_twos (
    .a_i (upper_c), .b_i (lower_c), .c_i (low_c),
    .s_o (top_s),   .co_o (top_c)
  );

  assign count_o = {top_c, top_s, low_s};
endmodule

// File: rtl/therm_adder_enc.sv
module therm_adder_enc import therm_enc_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid_i,
  input  logic [THERM_W-1:0] therm_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               code_vld_o
);
  therm_t cap_q, cap_d;
  logic   cap_vld_q, cap_vld_d;
  code_t  code_q, code_d;
  logic   vld_q, vld_d;
  code_t  tree_count;

  ones_adder_tree u_tree (
    .word_i  (cap_q),
    .count_o (tree_count)
  );

  // next-state
  always_comb begin
    cap_d     = cap_q;
    cap_vld_d = in_valid_i;
    if (in_valid_i) cap_d = therm_i;
    code_d = code_q;
    vld_d  = cap_vld_q;
    if (cap_vld_q) code_d = tree_count;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= '0;
      cap_vld_q <= 1'b0;
      code_q    <= '0;
      vld_q     <= 1'b0;
    end else begin
      cap_q     <= cap_d;
      cap_vld_q <= cap_vld_d;
      code_q    <= code_d;
      vld_q     <= vld_d;
    end
  end

  assign code_o     = code_q;
  assign code_vld_o = vld_q;
endmodule

// File: rtl/therm_adder_enc_chk.sv
module therm_adder_enc_chk import therm_enc_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid_i,
  input logic [THERM_W-1:0] therm_i,
  input logic [CODE_W-1:0]  code_o,
  input logic               code_vld_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (code_o == '0 && !code_vld_o));

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> ##1 code_vld_o);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |-> $past(in_valid_i, 2));

  a_r3_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_o |-> (code_o == CODE_W'($countones($past(therm_i, 2)))));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld_o |-> $stable(code_o));
endmodule

bind therm_adder_enc therm_adder_enc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .therm_i    (therm_i),
  .code_o     (code_o),
  .code_vld_o (code_vld_o)
);

// File: tb/therm_adder_enc_bench.sv
`timescale 1ns/1ps
module therm_adder_enc_bench;
  logic       clk;
  logic       rst_n;
  logic       in_valid_i;
  logic [6:0] therm_i;
  logic [2:0] code_o;
  logic       code_vld_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  therm_adder_enc u_therm_adder_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid_i),
    .therm_i    (therm_i),
    .code_o     (code_o),
    .code_vld_o (code_vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2:0] ref_count(input logic [6:0] w);
    int c = 0;
    for (int b = 0; b < 7; b++) c += int'(w[b]);
    return 3'(c);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // send one word and check the output pipeline around it
  task automatic send_one(input logic [6:0] w, input string req);
    @(negedge clk);
    in_valid_i = 1'b1; therm_i = w;
    @(negedge clk);
    in_valid_i = 1'b0;
    check("R4 not yet valid", int'(code_vld_o), 0);
    @(negedge clk);
    check("R4 valid", int'(code_vld_o), 1);
    check(req, int'(code_o), int'(ref_count(w)));
    @(negedge clk);
    check("R4 single pulse", int'(code_vld_o), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid_i = 1'b0; therm_i = '0;
    repeat (3) @(negedge clk);
    check("R1 code in reset", int'(code_o), 0);
    check("R1 valid in reset", int'(code_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(code_o), 0);
    check("R1 valid after release", int'(code_vld_o), 0);
  endtask

  task automatic test_thermometer();
    for (int k = 0; k <= 7; k++) begin
      logic [6:0] w;
      w = 7'((1 << k) - 1);
      send_one(w, "R2 thermometer code");
    end
  endtask

  task automatic test_stream_all();
    logic [6:0] hist [0:127];
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R6 stream valid", int'(code_vld_o), 1);
        check("R3 popcount", int'(code_o), int'(ref_count(hist[i-2])));
      end
      if (i < 128) begin
        hist[i] = 7'(i);
        in_valid_i = 1'b1; therm_i = 7'(i);
      end else begin
        in_valid_i = 1'b0;
      end
    end
    @(negedge clk);
    check("R5 valid after stream", int'(code_vld_o), 0);
  endtask

  task automatic test_idle_hold();
    send_one(7'b0111111, "R2 six ones");
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      therm_i = 7'(j * 37 + 5);
      check("R7 code held while idle", int'(code_o), 6);
      check("R5 valid low while idle", int'(code_vld_o), 0);
    end
    send_one(7'b1010010, "R3 bubble word");
  endtask

  initial begin
    test_reset();
    test_thermometer();
    test_stream_all();
    test_idle_hold();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule